// File: doc/BRIEF.md
# Host Bus Slave Interface

This block is the host-facing bus slave of a display controller. An external processor drives asynchronous strobes and chip selects against it: one select opens the register space, the other opens a direct window onto video memory. The block moves those pin levels into the system clock domain through synchronizer chains. For each strobe it issues exactly one request on an internal register port or memory port. It waits for that port's accept, then signals completion back to the processor on a three-state READY pin.

The data bus can be 16 bits wide, with separate write strobes for each byte lane. It can also be 8 bits wide. In that case the upper byte lane is unused and the upper write strobe pin carries the lowest address bit instead. Register accesses use one of two decode widths chosen by a mode pin: a narrow one, where only the low four byte-address bits select a register, or a wide one, where the low eight bits do. Read data is captured when the access is accepted. It is driven onto the bus only while a select and the read strobe are both active.

Top module: `hbus_slave`

## Requirements
- R1: With the register select (`cs_reg_n`) low and the read strobe (`rd_n`) low, exactly one request is raised on `reg_req_o`, with `acc_we_o` = 0, and no request is raised on `mem_req_o`.
- R2: With the memory select (`cs_mem_n`) low, requests go to `mem_req_o` only. `mem_addr_o` is the full byte address {`addr_i`, byte bit}, where the byte bit is 0 in 16-bit mode.
- R3: In 16-bit mode (`bus16_i` = 1), a write sets `acc_be_o[1]` from `wr_hi_n` low and `acc_be_o[0]` from `wr_lo_n` low, and passes `host_data_io` unchanged to `acc_wdata_o`. A 16-bit read requests both lanes (`acc_be_o` = 2'b11).
- R4: In 8-bit mode (`bus16_i` = 0), `wr_hi_n` is the byte address bit (1 = odd byte) and is never treated as a strobe. Only `wr_lo_n` writes, with `acc_be_o` = 2'b10 for an odd byte and 2'b01 for an even byte, and the low data byte copied into both write-data lanes. A read returns the selected lane on `host_data_io[7:0]` and leaves `host_data_io[15:8]` undriven.
- R5: `host_data_io` is driven by the block only while (`cs_reg_n` low or `cs_mem_n` low) and `rd_n` is low.
- R6: `host_ready_o` is undriven while both selects are high. It is driven high while a select is low and either no strobe is active or the access has not yet been accepted.
- R7: `host_ready_o` goes low no earlier than the clock edge after the addressed port raises its accept. It stays low for as long as the strobe is held.
- R8: The request stays high until accepted. A strobe that is held after acceptance starts no further request until it has been released.
- R9: Read data is captured in the accept cycle and stays on the bus unchanged while the strobe is held, even if the port's read data changes.
- R10: With `dmap_i` = 1 (narrow decode), `reg_addr_o` keeps byte-address bits 3..0 and forces bits 7..4 to zero. With `dmap_i` = 0 (wide decode), `reg_addr_o` carries byte-address bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus16_i | input | 1 | 1 = 16-bit host bus, 0 = 8-bit host bus |
| dmap_i | input | 1 | 1 = narrow register decode, 0 = wide register decode |
| cs_reg_n | input | 1 | Register-space select, active low |
| cs_mem_n | input | 1 | Video-memory select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_hi_n | input | 1 | Upper-lane write strobe (16-bit) or byte address bit (8-bit) |
| wr_lo_n | input | 1 | Lower-lane write strobe, active low |
| addr_i | input | 22 | Host address bits 22..1 |
| host_data_io | inout | 16 | Host data bus |
| host_ready_o | output | 1 | Three-state completion handshake, low = done |
| reg_req_o | output | 1 | Register port request |
| reg_addr_o | output | 8 | Register byte offset |
| reg_ack_i | input | 1 | Register port accept |
| reg_rdata_i | input | 16 | Register port read data |
| mem_req_o | output | 1 | Memory port request |
| mem_addr_o | output | 23 | Memory byte address |
| mem_ack_i | input | 1 | Memory port accept |
| mem_rdata_i | input | 16 | Memory port read data |
| acc_we_o | output | 1 | 1 = write access |
| acc_be_o | output | 2 | Byte-lane enables |
| acc_wdata_o | output | 16 | Write data |

## Verification
The bench checks READY in the cycle when accept is raised and again one cycle later. A design that signals completion combinationally from accept would show READY low too early. The bench also holds strobes well past completion and counts requests, which catches a design that re-arms while the strobe is still low. It flips the port's read data after completion, which exposes a design that feeds port data through instead of latching it. In 8-bit mode it asserts the dual-purpose pin low with no real strobe and expects no request, and it checks odd and even byte lanes in both decode widths. A design that mixed up the lane swap, the byte replication or the decode mask would show wrong enables, data or offsets.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  parameter int HB_AW  = 23;  // byte address width
  parameter int HB_RAW = 8;   // wide register decode width
  parameter int HB_RIW = 4;   // narrow register decode width
  localparam int HB_DW    = 16;
  localparam int HB_LANES = HB_DW / 8;

  typedef enum logic [1:0] {HB_IDLE, HB_REQ, HB_DONE} hb_state_e;

  typedef struct packed {
    logic [HB_AW-1:0]    baddr;
    logic [HB_RAW-1:0]   roff;
    logic [HB_LANES-1:0] be;
    logic [HB_DW-1:0]    wdata;
  } hb_cmd_t;

  // byte address from word address pins plus the byte bit
  function automatic logic [HB_AW-1:0] hb_byte_addr(
      input logic [HB_AW-2:0] waddr, input logic bus16, input logic a0);
    return {waddr, (bus16 ? 1'b0 : a0)};
  endfunction

  // register offset under the two decode widths
  function automatic logic [HB_RAW-1:0] hb_reg_offset(
      input logic [HB_AW-1:0] baddr, input logic narrow);
    logic [HB_RAW-1:0] mask;
    mask = narrow ? HB_RAW'((1 << HB_RIW) - 1) : {HB_RAW{1'b1}};
    return baddr[HB_RAW-1:0] & mask;
  endfunction

  // lane enables from width, byte bit, direction and synced strobes
  function automatic logic [HB_LANES-1:0] hb_lane_mask(
      input logic bus16, input logic a0, input logic is_rd,
      input logic hi_act, input logic lo_act);
    if (!bus16) return a0 ? 2'b10 : 2'b01;
    if (is_rd)  return 2'b11;
    return {hi_act, lo_act};
  endfunction

  function automatic logic [HB_DW-1:0] hb_wdata(
      input logic bus16, input logic [HB_DW-1:0] pins);
    return bus16 ? pins : {pins[7:0], pins[7:0]};
  endfunction

  // read lane steering for narrow bus
  function automatic logic [HB_DW-1:0] hb_rd_steer(
      input logic bus16, input logic a0, input logic [HB_DW-1:0] d);
    if (bus16) return d;
    return {8'h00, (a0 ? d[15:8] : d[7:0])};
  endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
(
  input  logic              bus16_i,
  input  logic              narrow_i,
  input  logic [HB_AW-2:0]  waddr_i,
  input  logic              a0_pin_i,
  input  logic              rd_s_i,
  input  logic              hi_s_i,
  input  logic              lo_s_i,
  input  logic [HB_DW-1:0]  data_pins_i,
  output hb_cmd_t           cmd_o
);
  logic [HB_AW-1:0] baddr_w;

  assign baddr_w     = hb_byte_addr(waddr_i, bus16_i, a0_pin_i);
  assign cmd_o.baddr = baddr_w;
  assign cmd_o.roff  = hb_reg_offset(baddr_w, narrow_i);
  assign cmd_o.be    = hb_lane_mask(bus16_i, baddr_w[0], rd_s_i, hi_s_i, lo_s_i);
  assign cmd_o.wdata = hb_wdata(bus16_i, data_pins_i);
endmodule

// File: rtl/hbus_fsm.sv
module hbus_fsm
  import hbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus16_i,
  input  logic             sel_reg_s_i,
  input  logic             sel_mem_s_i,
  input  logic             act_s_i,
  input  logic             rd_s_i,
  input  hb_cmd_t          cmd_i,
  input  logic             reg_ack_i,
  input  logic             mem_ack_i,
  input  logic [HB_DW-1:0] reg_rdata_i,
  input  logic [HB_DW-1:0] mem_rdata_i,
  output logic             req_o,
  output logic             tgt_reg_o,
  output logic             we_o,
  output hb_cmd_t          cmd_o,
  output logic [HB_DW-1:0] rdata_o,
  output logic             done_o
);
  hb_state_e        state_q;
  logic             start_w;
  logic             ack_sel_w;
  logic             release_w;
  logic [HB_DW-1:0] rsel_w;

  assign start_w   = (state_q == HB_IDLE) && (sel_reg_s_i || sel_mem_s_i) && act_s_i;
  assign ack_sel_w = tgt_reg_o ? reg_ack_i : mem_ack_i;
  assign release_w = !act_s_i || !(sel_reg_s_i || sel_mem_s_i);
  assign rsel_w    = tgt_reg_o ? reg_rdata_i : mem_rdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HB_IDLE;
      tgt_reg_o <= 1'b0;
      we_o      <= 1'b0;
      cmd_o     <= '0;
      rdata_o   <= '0;
    end else begin
      case (state_q)
        HB_IDLE: if (start_w) begin
          state_q   <= HB_REQ;
          tgt_reg_o <= sel_reg_s_i;
          we_o      <= !rd_s_i;
          cmd_o     <= cmd_i;
        end
        HB_REQ: if (ack_sel_w) begin
          state_q <= HB_DONE;
          if (!we_o) rdata_o <= hb_rd_steer(bus16_i, cmd_o.baddr[0], rsel_w);
        end
        HB_DONE: if (release_w) state_q <= HB_IDLE;
        default: state_q <= HB_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == HB_REQ);
  assign done_o = (state_q == HB_DONE);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_sel_w) |=> req_o); // R8
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(ack_sel_w)); // R7
  AST_NO_REQ_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_o); // R8
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> $stable(rdata_o)); // R9
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus16_i,
  input  logic              dmap_i,
  input  logic              cs_reg_n,
  input  logic              cs_mem_n,
  input  logic              rd_n,
  input  logic              wr_hi_n,
  input  logic              wr_lo_n,
  input  logic [HB_AW-2:0]  addr_i,
  inout  wire  [HB_DW-1:0]  host_data_io,
  output wire               host_ready_o,
  output logic              reg_req_o,
  output logic [HB_RAW-1:0] reg_addr_o,
  input  logic              reg_ack_i,
  input  logic [HB_DW-1:0]  reg_rdata_i,
  output logic              mem_req_o,
  output logic [HB_AW-1:0]  mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [HB_DW-1:0]  mem_rdata_i,
  output logic              acc_we_o,
  output logic [1:0]        acc_be_o,
  output logic [HB_DW-1:0]  acc_wdata_o
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_w, syn_w;
  logic sel_reg_s, sel_mem_s, rd_s, hi_s, lo_s, act_s;
  logic raw_sel, raw_act, data_oe, ready_lo;
  logic req_w, tgt_reg_w, we_w, done_w;
  hb_cmd_t          cmd_dec, cmd_q;
  logic [HB_DW-1:0] rdata_q;

  assign raw_w = {~cs_reg_n, ~cs_mem_n, ~rd_n, ~wr_hi_n, ~wr_lo_n};

  hbus_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(syn_w));

  assign {sel_reg_s, sel_mem_s, rd_s, hi_s, lo_s} = syn_w;
  assign act_s = rd_s || lo_s || (bus16_i && hi_s);

  hbus_decode u_dec (
    .bus16_i(bus16_i), .narrow_i(dmap_i), .waddr_i(addr_i),
    .a0_pin_i(wr_hi_n), .rd_s_i(rd_s), .hi_s_i(hi_s), .lo_s_i(lo_s),
    .data_pins_i(host_data_io), .cmd_o(cmd_dec));

  hbus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bus16_i(bus16_i),
    .sel_reg_s_i(sel_reg_s), .sel_mem_s_i(sel_mem_s), .act_s_i(act_s),
    .rd_s_i(rd_s), .cmd_i(cmd_dec),
    .reg_ack_i(reg_ack_i), .mem_ack_i(mem_ack_i),
    .reg_rdata_i(reg_rdata_i), .mem_rdata_i(mem_rdata_i),
    .req_o(req_w), .tgt_reg_o(tgt_reg_w), .we_o(we_w),
    .cmd_o(cmd_q), .rdata_o(rdata_q), .done_o(done_w));

  assign reg_req_o   = req_w && tgt_reg_w;
  assign mem_req_o   = req_w && !tgt_reg_w;
  assign reg_addr_o  = cmd_q.roff;
  assign mem_addr_o  = cmd_q.baddr;
  assign acc_we_o    = we_w;
  assign acc_be_o    = cmd_q.be;
  assign acc_wdata_o = cmd_q.wdata;

  // pin-side handshake and bus drivers follow the raw pins
  assign raw_sel  = !cs_reg_n || !cs_mem_n;
  assign raw_act  = !rd_n || !wr_lo_n || (bus16_i && !wr_hi_n);
  assign data_oe  = raw_sel && !rd_n;
  assign ready_lo = done_w && raw_act;

  assign host_ready_o        = raw_sel ? !ready_lo : 1'bz;
  assign host_data_io[7:0]   = data_oe ? rdata_q[7:0] : 8'hzz;
  assign host_data_io[15:8]  = (data_oe && bus16_i) ? rdata_q[15:8] : 8'hzz;

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req_o && mem_req_o)); // R1
  AST_CMD_STABLE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_w && $past(req_w)) |-> $stable(cmd_q)); // R8
endmodule

// File: tb/hbus_slave_tb_top.sv
module hbus_slave_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bus16, dmap, cs_reg_n, cs_mem_n, rd_n, wr_hi_n, wr_lo_n;
  logic [21:0] addr;
  logic        tb_drv;
  logic [15:0] tb_dat;
  wire  [15:0] hd;
  wire         rdy;
  logic        reg_req, mem_req, reg_ack, mem_ack, we;
  logic [7:0]  reg_addr;
  logic [22:0] mem_addr;
  logic [15:0] reg_rdata, mem_rdata, wdata;
  logic [1:0]  be;
  int compared = 0, mismatched = 0;
  int reg_cnt = 0, mem_cnt = 0;
  logic reg_prev = 0, mem_prev = 0;

  assign hd = tb_drv ? tb_dat : 16'hzzzz;
  genvar gi;
  generate for (gi = 0; gi < 16; gi++) begin : g_pu
    pullup (hd[gi]);
  end endgenerate
  pulldown (rdy);

  hbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus16_i(bus16), .dmap_i(dmap),
    .cs_reg_n(cs_reg_n), .cs_mem_n(cs_mem_n), .rd_n(rd_n),
    .wr_hi_n(wr_hi_n), .wr_lo_n(wr_lo_n), .addr_i(addr),
    .host_data_io(hd), .host_ready_o(rdy),
    .reg_req_o(reg_req), .reg_addr_o(reg_addr), .reg_ack_i(reg_ack),
    .reg_rdata_i(reg_rdata), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .acc_we_o(we), .acc_be_o(be), .acc_wdata_o(wdata));

  always @(posedge clk) begin
    if (reg_req && !reg_prev) reg_cnt++;
    if (mem_req && !mem_prev) mem_cnt++;
    reg_prev <= reg_req;
    mem_prev <= mem_req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // one full host access; hi/lo are strobe pin levels (hi is byte bit in 8-bit)
  task automatic access(input bit use_reg, input bit is_rd, input bit b16,
      input bit nar, input bit hi, input bit lo, input logic [21:0] a,
      input logic [15:0] wd, input logic [15:0] resp,
      input logic [22:0] exp_addr, input logic [1:0] exp_be,
      input logic [15:0] exp_wd, input logic [15:0] exp_rd, input string rq);
    int base_r, base_m, n;
    @(negedge clk);
    bus16 = b16; dmap = nar; addr = a;
    if (use_reg) cs_reg_n = 0; else cs_mem_n = 0;
    if (!is_rd) begin tb_drv = 1; tb_dat = wd; end
    if (!b16) wr_hi_n = hi;
    reg_rdata = resp; mem_rdata = resp;
    base_r = reg_cnt; base_m = mem_cnt;
    @(negedge clk);
    if (is_rd) rd_n = 0; else begin wr_lo_n = lo; if (b16) wr_hi_n = hi; end
    n = 0;
    while (!(reg_req || mem_req) && n < 20) begin @(negedge clk); n++; end
    chk("R6 ready high while pending", 32'(rdy), 32'd1);
    chk({rq, " port select reg"}, 32'(reg_req), 32'(use_reg));
    chk({rq, " port select mem"}, 32'(mem_req), 32'(!use_reg));
    chk("R1 direction", 32'(we), 32'(!is_rd));
    if (use_reg) chk({rq, " reg_addr"}, 32'(reg_addr), 32'(exp_addr[7:0]));
    else chk({rq, " mem_addr"}, 32'(mem_addr), 32'(exp_addr));
    chk({rq, " lane enables"}, 32'(be), 32'(exp_be));
    if (!is_rd) chk({rq, " write data"}, 32'(wdata), 32'(exp_wd));
    if (use_reg) reg_ack = 1; else mem_ack = 1;
    #1 chk("R7 ready high in accept cycle", 32'(rdy), 32'd1);
    @(negedge clk);
    reg_ack = 0; mem_ack = 0;
    #1 chk("R7 ready low after accept", 32'(rdy), 32'd0);
    if (is_rd) begin
      if (b16) chk({rq, " read data"}, 32'(hd), 32'(exp_rd));
      else begin
        chk({rq, " read low lane"}, 32'(hd[7:0]), 32'(exp_rd[7:0]));
        chk("R4 upper lane undriven", 32'(hd[15:8]), 32'hFF);
      end
      reg_rdata = ~resp; mem_rdata = ~resp;
    end
    repeat (6) @(negedge clk);
    chk("R8 single request", 32'((reg_cnt - base_r) + (mem_cnt - base_m)), 32'd1);
    chk("R7 ready held low", 32'(rdy), 32'd0);
    if (is_rd) begin
      if (b16) chk("R9 read data held", 32'(hd), 32'(exp_rd));
      else chk("R9 read data held", 32'(hd[7:0]), 32'(exp_rd[7:0]));
    end
    rd_n = 1; wr_lo_n = 1; if (b16) wr_hi_n = 1; tb_drv = 0;
    #1 chk("R6 ready high after release", 32'(rdy), 32'd1);
    chk("R5 bus released", 32'(hd), 32'hFFFF);
    repeat (4) @(negedge clk);
    cs_reg_n = 1; cs_mem_n = 1; wr_hi_n = 1;
    #1 chk("R6 ready undriven without select", 32'(rdy), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R6 reset ready undriven", 32'(rdy), 32'd0);
    chk("R5 reset bus undriven", 32'(hd), 32'hFFFF);
    chk("R8 reset no request", 32'(reg_req || mem_req), 32'd0);
  endtask

  task automatic t_select_idle();
    @(negedge clk); bus16 = 1; cs_reg_n = 0;
    repeat (6) @(negedge clk);
    chk("R6 select without strobe ready high", 32'(rdy), 32'd1);
    chk("R5 select without read bus undriven", 32'(hd), 32'hFFFF);
    chk("R1 no request without strobe", 32'(reg_req), 32'd0);
    cs_reg_n = 1; repeat (3) @(negedge clk);
  endtask

  task automatic t_a0_not_strobe();
    int base;
    @(negedge clk); bus16 = 0; cs_reg_n = 0; wr_hi_n = 0;
    base = reg_cnt;
    repeat (8) @(negedge clk);
    chk("R4 byte bit is not a strobe", 32'(reg_cnt - base), 32'd0);
    chk("R4 ready high with no strobe", 32'(rdy), 32'd1);
    cs_reg_n = 1; wr_hi_n = 1; repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; bus16 = 1; dmap = 0; cs_reg_n = 1; cs_mem_n = 1; rd_n = 1;
    wr_hi_n = 1; wr_lo_n = 1; addr = 0; tb_drv = 0; tb_dat = 0;
    reg_ack = 0; mem_ack = 0; reg_rdata = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_select_idle();
    // 16-bit wide-decode register read: byte addr 0x2AAAA6 -> offset A6
    access(1, 1, 1, 0, 1, 1, 22'h155553, 16'h0, 16'hBEEF, 23'h0000A6, 2'b11, 16'h0, 16'hBEEF, "R10 R1");
    // 16-bit narrow-decode register write, both lanes -> offset 06
    access(1, 0, 1, 1, 0, 0, 22'h155553, 16'h1357, 16'h0, 23'h000006, 2'b11, 16'h1357, 16'h0, "R10 R3");
    // 16-bit memory write, upper lane only
    access(0, 0, 1, 0, 0, 1, 22'h155553, 16'hA55A, 16'h0, 23'h2AAAA6, 2'b10, 16'hA55A, 16'h0, "R2 R3");
    // 16-bit memory write, lower lane only
    access(0, 0, 1, 0, 1, 0, 22'h0F0F0F, 16'h00C3, 16'h0, 23'h1E1E1E, 2'b01, 16'h00C3, 16'h0, "R2 R3");
    // 16-bit memory read
    access(0, 1, 1, 0, 1, 1, 22'h3FFFFF, 16'h0, 16'h8421, 23'h7FFFFE, 2'b11, 16'h0, 16'h8421, "R2 R9");
    // 8-bit memory write, odd byte, data replicated
    access(0, 0, 0, 0, 1, 0, 22'h155553, 16'hFF3C, 16'h0, 23'h2AAAA7, 2'b10, 16'h3C3C, 16'h0, "R4 R2");
    // 8-bit register read, even byte, wide decode
    access(1, 1, 0, 0, 0, 1, 22'h155553, 16'h0, 16'h9A5B, 23'h0000A6, 2'b01, 16'h0, 16'h005B, "R4 R10");
    // 8-bit register read, odd byte, wide decode
    access(1, 1, 0, 0, 1, 1, 22'h155553, 16'h0, 16'h9A5B, 23'h0000A7, 2'b10, 16'h0, 16'h009A, "R4 R10");
    // 8-bit register write, odd byte, narrow decode -> offset 07
    access(1, 0, 0, 1, 1, 0, 22'h155553, 16'h0066, 16'h0, 23'h000007, 2'b10, 16'h6666, 16'h0, "R4 R10");
    t_a0_not_strobe();
    summary();
    $finish;
  end
endmodule